// File: doc/BRIEF.md
# Store Buffer with Selectable Store Ordering

This block sits between one in-order processor's memory port and a single-ported word memory. Stores are accepted into a small buffer, kept in age order, so the processor can move on before they reach memory. Loads to addresses with no buffered store go straight to memory and may finish before older buffered stores. A load that matches a buffered store takes the youngest matching data from the buffer and does not touch memory.

A mode input picks the write ordering. With `pso_mode` low, stores leave the buffer oldest first. With `pso_mode` high, the block drains the youngest store that is allowed to go. A store is allowed to go when no older buffered store has the same address and no store-ordering fence lies between it and the oldest entry.

Fences are typed. A store-to-store fence is acknowledged the cycle after it is raised and leaves a barrier behind it. A fence that orders stores before loads waits until the buffer is empty. While a fence is waiting, no load is issued to memory and no store is accepted.

Top module: `store_order_buffer`

## Requirements
- R1: A load whose address matches no buffered store is issued to memory ahead of buffered stores. `ld_done` is high in the cycle where `mem_ready` accepts the read, and `ld_data` equals `mem_rdata` in that cycle.
- R2: A load whose full address matches one or more buffered stores completes in the cycle it is presented. It returns the data of the youngest matching store and issues no memory read.
- R3: With `pso_mode`=0, stores are written to memory in the order the processor presented them.
- R4: With `pso_mode`=1, each write goes to the youngest eligible buffered store. Stores to the same address are still written in program order.
- R5: With `pso_mode`=1, a store presented after an acknowledged store-to-store fence is not written until every store presented before that fence has been written.
- R6: `fence_kind` bit 0 set means the fence orders stores before later loads. Such a fence is acknowledged only in a cycle where the buffer is empty. Until the acknowledgement, no load completes or goes to memory. If the buffer is already empty, the acknowledgement comes in the cycle after `fence_valid` is raised.
- R7: A fence with `fence_kind` = 2'b10 (store-to-store only) is acknowledged in the cycle after `fence_valid` is raised, whatever the buffer holds.
- R8: When the buffer holds DEPTH stores, `st_ready` is low and the processor stalls.
- R9: Once a load has taken the memory port over a waiting store in STARVE arbitrations (default 16), the next arbitration goes to the store.
- R10: After reset the buffer is empty: `st_ready` is high, and `mem_req`, `fence_ack` and `ld_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pso_mode | input | 1 | 0: stores drain in program order; 1: relaxed store order |
| st_valid | input | 1 | Processor presents a store |
| st_ready | output | 1 | Store accepted at this edge when high with st_valid |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Processor presents a load (held until ld_done) |
| ld_addr | input | AW | Load word address |
| ld_done | output | 1 | Load completes this cycle |
| ld_data | output | DW | Load result, valid with ld_done |
| fence_valid | input | 1 | Fence request, held until fence_ack |
| fence_kind | input | 2 | Bit 0: order stores before loads; bit 1: order stores before stores |
| fence_ack | output | 1 | Fence ordering holds; one-cycle pulse |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Read data, valid in the accepting cycle |

## Verification
The assertions assume a processor that never presents a load and a store in the same cycle. They also assume that `fence_valid`, `fence_kind` and a presented load's address stay stable until acknowledged, and that the memory takes a request only in the cycle `mem_ready` is high, answering reads in that same cycle. The bench keeps to these rules: its tasks drive one operation at a time, hold each request until its handshake is seen, and answer reads from a model that looks up the current address with no added latency. Back-pressure is applied only through `mem_ready`. The bench holds it low to fill the buffer and to build up the orderings under test.

// File: rtl/store_order_buffer.sv
`timescale 1ns/1ps
module store_order_buffer #(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int DEPTH  = 8,
  parameter int STARVE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pso_mode,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_done,
  output logic [DW-1:0] ld_data,
  input  logic          fence_valid,
  input  logic [1:0]    fence_kind,
  output logic          fence_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SW = $clog2(STARVE + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic          bar_q  [DEPTH];
  logic [AW-1:0] addr_n [DEPTH];
  logic [DW-1:0] data_n [DEPTH];
  logic          bar_n  [DEPTH];
  logic [CW-1:0] count;
  logic [SW-1:0] wait_cnt;
  logic          fence_pend, bar_pend;

  logic          hit;
  logic [DW-1:0] fwd_data;
  logic [IW-1:0] sel;
  logic          load_go, ld_mem, starved, st_grant, drain, push, fence_ok;
  logic          nonempty;

  assign nonempty = (count != '0);

  always_comb begin
    hit = 1'b0;
    fwd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < count && addr_q[i] == ld_addr) begin
        hit = 1'b1;
        fwd_data = data_q[i];
      end
    end
  end

  always_comb begin
    logic ok;
    sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      ok = (CW'(i) < count);
      for (int j = 0; j < DEPTH; j++) begin
        if (j < i && addr_q[j] == addr_q[i]) ok = 1'b0;
        if (j > 0 && j <= i && bar_q[j]) ok = 1'b0;
      end
      if (ok && pso_mode) sel = IW'(i);
    end
  end

  assign load_go   = ld_valid & ~fence_pend;
  assign ld_mem    = load_go & ~hit;
  assign starved   = (wait_cnt >= SW'(STARVE));
  assign st_grant  = nonempty & (~ld_mem | starved);
  assign drain     = st_grant & mem_ready;

  assign mem_req   = ld_mem | nonempty;
  assign mem_we    = st_grant;
  assign mem_addr  = st_grant ? addr_q[sel] : ld_addr;
  assign mem_wdata = data_q[sel];

  assign ld_done   = load_go & (hit | (~st_grant & mem_ready));
  assign ld_data   = hit ? fwd_data : mem_rdata;

  assign st_ready  = (count != CW'(DEPTH)) & ~fence_pend;
  assign push      = st_valid & st_ready;

  assign fence_ok  = fence_kind[0] ? ~nonempty : 1'b1;
  assign fence_ack = fence_pend & fence_ok;

  always_comb begin
    logic [IW-1:0] pidx;
    for (int i = 0; i < DEPTH; i++) begin
      addr_n[i] = addr_q[i];
      data_n[i] = data_q[i];
      bar_n[i]  = bar_q[i];
    end
    if (drain) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IW'(i) >= sel) begin
          addr_n[i] = addr_q[i+1];
          data_n[i] = data_q[i+1];
          bar_n[i]  = bar_q[i+1];
        end
      end
    end
    pidx = IW'(count - CW'(drain));
    if (push) begin
      addr_n[pidx] = st_addr;
      data_n[pidx] = st_data;
      bar_n[pidx]  = bar_pend;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count      <= '0;
      wait_cnt   <= '0;
      fence_pend <= 1'b0;
      bar_pend   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
        bar_q[i]  <= 1'b0;
      end
    end else begin
      count      <= count + CW'(push) - CW'(drain);
      fence_pend <= fence_valid & ~fence_ack;
      if (push)                             bar_pend <= 1'b0;
      else if (fence_ack && fence_kind[1])  bar_pend <= 1'b1;
      if (drain)                                         wait_cnt <= '0;
      else if (nonempty && ld_mem && !st_grant && !starved) wait_cnt <= wait_cnt + 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= addr_n[i];
        data_q[i] <= data_n[i];
        bar_q[i]  <= bar_n[i];
      end
    end
  end

  a_r10_reset_empty: assert property (@(posedge clk) !rst_n |=> (!mem_req && st_ready && !fence_ack));
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !drain) |=> (count == CW'(DEPTH)));
  a_r2_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && hit && !fence_pend) |-> !(mem_req && !mem_we));
  a_r3_tso_head: assert property (@(posedge clk) disable iff (!rst_n)
    (!pso_mode && drain) |-> (mem_addr == addr_q[0] && mem_wdata == data_q[0]));
  a_r6_fence_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_ack && fence_kind[0]) |-> !(mem_req && mem_we));
  a_r6_no_load_past_fence: assert property (@(posedge clk) disable iff (!rst_n)
    fence_pend |-> !(mem_req && !mem_we) && !ld_done);
  a_r7_ss_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_pend && fence_kind == 2'b10) |-> fence_ack);
  a_r9_starve: assert property (@(posedge clk) disable iff (!rst_n)
    (starved && nonempty) |-> mem_we);
endmodule

// File: tb/store_order_buffer_test.sv
`timescale 1ns/1ps
module store_order_buffer_test;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0, pso_mode = 1'b0;
  logic st_valid = 1'b0, st_ready;
  logic [AW-1:0] st_addr = '0, ld_addr = '0, mem_addr;
  logic [DW-1:0] st_data = '0, ld_data, mem_wdata, mem_rdata;
  logic ld_valid = 1'b0, ld_done;
  logic fence_valid = 1'b0, fence_ack;
  logic [1:0] fence_kind = 2'b00;
  logic mem_req, mem_we, mem_ready = 1'b0;

  int errors = 0, checks = 0;
  logic [DW-1:0] memarr [256];
  logic [DW-1:0] shadow [256];
  logic [AW+DW-1:0] expq [$];

  always #2.5 clk = ~clk;

  store_order_buffer #(.AW(AW), .DW(DW), .DEPTH(8), .STARVE(16)) uut (
    .clk(clk), .rst_n(rst_n), .pso_mode(pso_mode),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_done(ld_done), .ld_data(ld_data),
    .fence_valid(fence_valid), .fence_kind(fence_kind), .fence_ack(fence_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  assign mem_rdata = memarr[mem_addr];
  always @(posedge clk) if (mem_req && mem_we && mem_ready) memarr[mem_addr] <= mem_wdata;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we && mem_ready) begin
      if (expq.size() == 0) chk(1'b0, "R3/R4/R5 unexpected write", {mem_addr, mem_wdata}, 0);
      else begin
        logic [AW+DW-1:0] e;
        e = expq.pop_front();
        chk({mem_addr, mem_wdata} == e, "R3/R4/R5 write order", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit enq);
    st_valid = 1'b1; st_addr = a; st_data = d;
    shadow[a] = d;
    if (enq) expq.push_back({a, d});
    forever begin
      @(negedge clk);
      if (st_ready) break;
    end
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk);
      if (!mem_req) break;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      memarr[i] = 32'h1000 + i;
      shadow[i] = 32'h1000 + i;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(st_ready && !mem_req && !fence_ack && !ld_done, "R10 reset state",
        {st_ready, mem_req, fence_ack, ld_done}, 4'b1000);
    @(posedge clk); #1;

    // R8, R1, R3 in ordered mode
    pso_mode = 1'b0; mem_ready = 1'b0;
    for (int i = 1; i <= 8; i++) store(AW'(i), 32'hA0 + i, 1'b1);
    @(negedge clk);
    chk(!st_ready, "R8 full stalls", st_ready, 0);
    @(posedge clk); #1;
    ld_valid = 1'b1; ld_addr = 8'd12; mem_ready = 1'b1;
    @(negedge clk);
    chk(ld_done && !mem_we && ld_data == shadow[12], "R1 load bypasses stores", ld_data, shadow[12]);
    @(posedge clk); #1;
    ld_valid = 1'b0;
    wait_idle();
    chk(expq.size() == 0, "R3 all writes in order", expq.size(), 0);

    // R2 forwarding of youngest match
    mem_ready = 1'b0;
    store(8'd20, 32'h11, 1'b1);
    store(8'd21, 32'h22, 1'b1);
    store(8'd20, 32'h33, 1'b1);
    ld_valid = 1'b1; ld_addr = 8'd20;
    @(negedge clk);
    chk(ld_done && ld_data == 32'h33, "R2 youngest forward", ld_data, 32'h33);
    chk(!(mem_req && !mem_we), "R2 no memory read on hit", mem_req && !mem_we, 0);
    @(posedge clk); #1;
    ld_valid = 1'b0; mem_ready = 1'b1;
    wait_idle();
    chk(expq.size() == 0 && memarr[20] == 32'h33, "R2 final value", memarr[20], 32'h33);

    // R6 store-to-load fence
    mem_ready = 1'b0;
    store(8'd70, 32'h70, 1'b1);
    store(8'd71, 32'h71, 1'b1);
    fence_valid = 1'b1; fence_kind = 2'b01;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(!fence_ack, "R6 fence waits for drain", fence_ack, 0);
      if (c == 1) begin
        @(posedge clk); #1;
        ld_valid = 1'b1; ld_addr = 8'd70;
        @(negedge clk);
        chk(!ld_done, "R6 load held behind fence", ld_done, 0);
      end
      @(posedge clk); #1;
    end
    ld_valid = 1'b0; mem_ready = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (fence_ack) break;
      @(posedge clk); #1;
    end
    chk(fence_ack && expq.size() == 0, "R6 ack after all stores written", expq.size(), 0);
    @(posedge clk); #1;
    fence_valid = 1'b0;
    @(posedge clk); #1;
    ld_valid = 1'b1; ld_addr = 8'd70;
    @(negedge clk);
    chk(ld_done && ld_data == 32'h70, "R6 load after fence", ld_data, 32'h70);
    @(posedge clk); #1;
    ld_valid = 1'b0;
    fence_valid = 1'b1; fence_kind = 2'b11;
    @(negedge clk);
    chk(!fence_ack, "R6 empty fence not same cycle", fence_ack, 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk(fence_ack, "R6 empty fence next cycle", fence_ack, 1);
    @(posedge clk); #1;
    fence_valid = 1'b0;

    // R4 relaxed order, same address kept in order
    pso_mode = 1'b1; mem_ready = 1'b0;
    store(8'd30, 32'hD1, 1'b0);
    store(8'd31, 32'hD2, 1'b0);
    store(8'd30, 32'hD3, 1'b0);
    store(8'd32, 32'hD4, 1'b0);
    expq.push_back({8'd32, 32'hD4});
    expq.push_back({8'd31, 32'hD2});
    expq.push_back({8'd30, 32'hD1});
    expq.push_back({8'd30, 32'hD3});
    mem_ready = 1'b1;
    wait_idle();
    chk(expq.size() == 0 && memarr[30] == 32'hD3, "R4 relaxed drain order", memarr[30], 32'hD3);

    // R7, R5 store-to-store fence in relaxed mode
    mem_ready = 1'b0;
    store(8'd40, 32'hE1, 1'b0);
    store(8'd41, 32'hE2, 1'b0);
    fence_valid = 1'b1; fence_kind = 2'b10;
    @(negedge clk);
    chk(!fence_ack, "R7 no same-cycle ack", fence_ack, 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk(fence_ack, "R7 ack next cycle", fence_ack, 1);
    @(posedge clk); #1;
    fence_valid = 1'b0;
    store(8'd42, 32'hE3, 1'b0);
    store(8'd43, 32'hE4, 1'b0);
    expq.push_back({8'd41, 32'hE2});
    expq.push_back({8'd40, 32'hE1});
    expq.push_back({8'd43, 32'hE4});
    expq.push_back({8'd42, 32'hE3});
    mem_ready = 1'b1;
    wait_idle();
    chk(expq.size() == 0, "R5 barrier order", expq.size(), 0);

    // R9 starvation guard
    pso_mode = 1'b0; mem_ready = 1'b0;
    store(8'd50, 32'h55, 1'b1);
    ld_valid = 1'b1; ld_addr = 8'd60; mem_ready = 1'b1;
    begin
      int n;
      n = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (mem_we) break;
        if (ld_done) n++;
        @(posedge clk); #1;
      end
      chk(n == 16 && mem_we, "R9 store wins after 16 losses", n, 16);
    end
    @(posedge clk); #1;
    ld_valid = 1'b0;
    wait_idle();
    chk(expq.size() == 0 && memarr[50] == 32'h55, "R9 store written", memarr[50], 32'h55);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule